// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a running BCD clock (seconds, minutes, hours) and raises a sticky alarm flag when the time equals a programmed alarm setting. Each of the three alarm bytes carries its own mask bit. A masked field is left out of the comparison, so one block can serve as a once-a-day alarm, a once-an-hour alarm, a once-a-minute alarm or a once-a-second tick, depending on which fields are masked.

The comparison is made only on a one-second tick. A match that lasts a whole second therefore sets the flag once. Software reads the flags byte to collect the event, and that read clears the flag. The interrupt output normally follows the flag. A calibration bit in the flags byte turns the output into a square wave instead: the wave is divided down from a 32.768 kHz enable, so that the oscillator frequency can be measured at the pin.

Top module: `bcd_alarm_unit`

## Requirements
- R1: After reset, the alarm flag is 0, the interrupt output is 0, the calibration bit is 0, and all three alarm bytes read back as 0x00.
- R2: The register address map is fixed as follows: 0 is the flags byte, 1 is alarm seconds, 2 is alarm minutes and 3 is alarm hours. A read strobe loads `rd_data` at the next clock edge, and the value then holds until the next read. The seconds and minutes bytes read back exactly as written. The hours byte always reads bit 6 as 0.
- R3: Bit 7 of each alarm byte is its mask. When the bit is 0, the field must equal the time for a match. When the bit is 1, the field is ignored.
- R4: The hours field compares bits 5:0 only. The minutes and seconds fields compare bits 6:0 only. The other bits of the time inputs have no effect on the match.
- R5: The alarm flag is set only at a clock edge where `sec_tick` is 1 and every unmasked field matches. The flag is visible in the cycle after the tick. A matching time without a tick leaves the flag unchanged.
- R6: The flag is sticky until the flags byte is read. A flags read returns the flag at bit 6 and clears it at the same edge. A write to the flags byte never changes the flag. Bits 7, 5:3 and 1:0 of the flags byte read as 0.
- R7: If a flags read and a tick with a match fall on the same edge, the flag ends up set. The read returns the flag's value from before that edge.
- R8: When all three mask bits are 1, every tick sets the flag.
- R9: Bit 2 of the flags byte is the calibration enable. It can be written and read back. While it is 0, `int_out` equals the alarm flag.
- R10: While calibration is on, `int_out` is a square wave. The wave starts low when calibration is turned on and changes level after every `CAL_DIV/2` cycles in which `osc_en` is 1. The default of 64 gives 512 Hz from a 32.768 kHz enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hr | input | 8 | Current hours, BCD |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_en | input | 1 | 32.768 kHz clock enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| int_out | output | 1 | Interrupt level, or the calibration square wave |

## Verification
A wrong stored mask or a wrong alarm digit shows up at `alarm_flag` one cycle after the tick that should, or should not, have produced a match. A corrupted alarm byte also appears in `rd_data` one cycle after a read strobe. A flag clear-versus-set ordering error is caught in the cycle after a read collides with a tick. A divider count that is off by even one changes the measured high and low time of `int_out`, and the error appears within the first full wave period.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

   localparam int NFLD     = 3;
   localparam int FLD_SEC  = 0;
   localparam int FLD_MIN  = 1;
   localparam int FLD_HR   = 2;

   localparam int MASK_BIT = 7;
   localparam int AF_BIT   = 6;
   localparam int CAL_BIT  = 2;

   localparam logic [7:0] FLAGS_ADDR = 8'd0;

   // bits of a field that take part in the comparison
   function automatic logic [7:0] value_bits(input int fld);
      return (fld == FLD_HR) ? 8'h3F : 8'h7F;
   endfunction

   // bits of a field that are kept in storage
   function automatic logic [7:0] store_bits(input int fld);
      return value_bits(fld) | (8'h1 << MASK_BIT);
   endfunction

endpackage

// File: rtl/bcd_alarm_regfile.sv
module bcd_alarm_regfile
   import bcd_alarm_pkg::*;
#(
   parameter int         AW      = 2,
   parameter logic [7:0] ALM_RST = 8'h00
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [AW-1:0]              addr,
   input  logic [7:0]                 wr_data,
   input  logic                       af_now,
   output logic [7:0]                 rd_data,
   output logic [NFLD-1:0][7:0]       alarm_q,
   output logic                       cal_q,
   output logic                       flags_rd
);

   logic          hit_flags;
   logic [7:0]    flags_byte;
   logic [7:0]    rd_mux;

   assign hit_flags = (addr == AW'(FLAGS_ADDR));
   assign flags_rd  = rd_en && hit_flags;

   always_comb begin
      flags_byte          = '0;
      flags_byte[AF_BIT]  = af_now;
      flags_byte[CAL_BIT] = cal_q;
   end

   // calibration enable lives in the flags byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cal_q <= 1'b0;
      else if (wr_en && hit_flags)
         cal_q <= wr_data[CAL_BIT];
   end

   // one storage byte per alarm field, at address field+1
   for (genvar i = 0; i < NFLD; i++) begin : g_alm
      localparam logic [7:0] KEEP = store_bits(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alarm_q[i] <= ALM_RST & KEEP;
         else if (wr_en && (addr == AW'(i + 1)))
            alarm_q[i] <= wr_data & KEEP;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_flags)
         rd_mux = flags_byte;
      for (int k = 0; k < NFLD; k++) begin
         if (addr == AW'(k + 1))
            rd_mux = alarm_q[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_mux;
   end

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
   import bcd_alarm_pkg::*;
(
   input  logic [NFLD-1:0][7:0] now_fld,
   input  logic [NFLD-1:0][7:0] alarm_fld,
   output logic [NFLD-1:0]      mask_on,
   output logic                 hit
);

   logic [NFLD-1:0] fld_ok;

   for (genvar i = 0; i < NFLD; i++) begin : g_cmp
      localparam logic [7:0] VB = value_bits(i);
      logic same;
      assign mask_on[i] = alarm_fld[i][MASK_BIT];
      assign same       = ((now_fld[i] & VB) == (alarm_fld[i] & VB));
      assign fld_ok[i]  = mask_on[i] || same;
   end

   assign hit = &fld_ok;

endmodule

// File: rtl/bcd_alarm_caldiv.sv
module bcd_alarm_caldiv #(
   parameter int CAL_DIV = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cal_on,
   input  logic osc_en,
   output logic wave
);

   localparam int HALF = CAL_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         wave <= 1'b0;
      end else if (!cal_on) begin
         cnt  <= '0;
         wave <= 1'b0;
      end else if (osc_en) begin
         if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            wave <= ~wave;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit
   import bcd_alarm_pkg::*;
#(
   parameter int         AW      = 2,
   parameter int         CAL_DIV = 64,
   parameter logic [7:0] ALM_RST = 8'h00
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wr_data,
   output logic [7:0]    rd_data,
   input  logic [7:0]    now_sec,
   input  logic [7:0]    now_min,
   input  logic [7:0]    now_hr,
   input  logic          sec_tick,
   input  logic          osc_en,
   output logic          alarm_flag,
   output logic          int_out
);

   if (AW < 2) begin : g_bad_aw
      $error("bcd_alarm_unit: AW must be at least 2");
   end
   if ((CAL_DIV < 4) || (CAL_DIV % 2 != 0)) begin : g_bad_div
      $error("bcd_alarm_unit: CAL_DIV must be even and at least 4");
   end

   logic [NFLD-1:0][7:0] alarm_q;
   logic [NFLD-1:0][7:0] now_fld;
   logic [NFLD-1:0]      mask_on;
   logic                 hit;
   logic                 cal_q;
   logic                 flags_rd;
   logic                 af_q;
   logic                 wave;

   assign now_fld[FLD_SEC] = now_sec;
   assign now_fld[FLD_MIN] = now_min;
   assign now_fld[FLD_HR]  = now_hr;

   bcd_alarm_regfile #(.AW(AW), .ALM_RST(ALM_RST)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .af_now   (af_q),
      .rd_data  (rd_data),
      .alarm_q  (alarm_q),
      .cal_q    (cal_q),
      .flags_rd (flags_rd)
   );

   bcd_alarm_match u_match (
      .now_fld   (now_fld),
      .alarm_fld (alarm_q),
      .mask_on   (mask_on),
      .hit       (hit)
   );

   bcd_alarm_caldiv #(.CAL_DIV(CAL_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .cal_on (cal_q),
      .osc_en (osc_en),
      .wave   (wave)
   );

   // set has priority over the read-clear so no event is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         af_q <= 1'b0;
      else if (sec_tick && hit)
         af_q <= 1'b1;
      else if (flags_rd)
         af_q <= 1'b0;
   end

   assign alarm_flag = af_q;
   assign int_out    = cal_q ? wave : af_q;

endmodule

// File: rtl/bcd_alarm_unit_chk.sv
module bcd_alarm_unit_chk #(
   parameter int AW = 2
)(
   input logic          clk,
   input logic          rst_n,
   input logic          rd_en,
   input logic [AW-1:0] addr,
   input logic          sec_tick,
   input logic          osc_en,
   input logic          alarm_flag,
   input logic          int_out,
   input logic          cal_q,
   input logic          hit,
   input logic [2:0]    mask_on
);

   p_rise_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(sec_tick))
      else $error("alarm flag rose without a tick");

   p_fall_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_flag) |-> $past(rd_en && (addr == '0)))
      else $error("alarm flag cleared without a flags read");

   p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && hit) |=> alarm_flag)
      else $error("match on tick did not leave flag set");

   p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && (&mask_on)) |=> alarm_flag)
      else $error("fully masked alarm did not fire");

   p_int_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_q |-> (int_out == alarm_flag))
      else $error("interrupt does not follow flag");

   p_wave_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_q && !osc_en) |=> (!cal_q || $stable(int_out)))
      else $error("calibration wave moved without an enable");

endmodule

bind bcd_alarm_unit bcd_alarm_unit_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .addr       (addr),
   .sec_tick   (sec_tick),
   .osc_en     (osc_en),
   .alarm_flag (alarm_flag),
   .int_out    (int_out),
   .cal_q      (cal_q),
   .hit        (hit),
   .mask_on    (mask_on)
);

// File: tb/sim_bcd_alarm_unit.sv
`timescale 1ns/1ps
module sim_bcd_alarm_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] now_sec = '0;
   logic [7:0] now_min = '0;
   logic [7:0] now_hr = '0;
   logic       sec_tick = 1'b0;
   logic       osc_en = 1'b0;
   logic       alarm_flag;
   logic       int_out;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   bcd_alarm_unit u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .now_sec(now_sec),
      .now_min(now_min), .now_hr(now_hr), .sec_tick(sec_tick),
      .osc_en(osc_en), .alarm_flag(alarm_flag), .int_out(int_out)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic do_tick(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      @(negedge clk);
      now_hr = h; now_min = m; now_sec = s; sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic clear_flag();
      logic [7:0] d;
      reg_rd(2'd0, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 flag", alarm_flag, 0);
      check("R1 int", int_out, 0);
      for (int a = 0; a < 4; a++) begin
         reg_rd(2'(a), d);
         check("R1 reg reset", d, 0);
      end
   endtask

   task automatic t_readback();
      logic [7:0] d;
      reg_wr(2'd1, 8'hD9); reg_wr(2'd2, 8'h45); reg_wr(2'd3, 8'hFF);
      reg_rd(2'd1, d); check("R2 sec readback", d, 8'hD9);
      reg_rd(2'd2, d); check("R2 min readback", d, 8'h45);
      reg_rd(2'd3, d); check("R2 hr bit6 zero", d, 8'hBF);
      @(negedge clk);
      check("R2 rd_data holds", rd_data, 8'hBF);
   endtask

   task automatic t_exact();
      reg_wr(2'd1, 8'h30); reg_wr(2'd2, 8'h15); reg_wr(2'd3, 8'h12);
      do_tick(8'h12, 8'h15, 8'h29);
      check("R5 near miss", alarm_flag, 0);
      @(negedge clk);
      now_sec = 8'h30;
      repeat (3) @(negedge clk);
      check("R5 match without tick", alarm_flag, 0);
      do_tick(8'h12, 8'h15, 8'h30);
      check("R5 match on tick", alarm_flag, 1);
      check("R9 int follows flag", int_out, 1);
      do_tick(8'h12, 8'h15, 8'h31);
      repeat (4) @(negedge clk);
      check("R6 sticky", alarm_flag, 1);
   endtask

   task automatic t_read_clear();
      logic [7:0] d;
      reg_rd(2'd0, d);
      check("R6 read shows flag at bit6", d, 8'h40);
      check("R6 cleared by read", alarm_flag, 0);
      reg_rd(2'd0, d);
      check("R6 second read", d, 8'h00);
      reg_wr(2'd0, 8'h40);
      check("R6 flag not writable", alarm_flag, 0);
      reg_rd(2'd0, d);
      check("R6 flags byte after write", d, 8'h00);
   endtask

   task automatic t_mask();
      reg_wr(2'd1, 8'hB0);
      do_tick(8'h12, 8'h15, 8'h07);
      check("R3 seconds masked", alarm_flag, 1);
      clear_flag();
      reg_wr(2'd1, 8'h30);
      do_tick(8'h12, 8'h15, 8'h07);
      check("R3 seconds unmasked", alarm_flag, 0);
      reg_wr(2'd3, 8'h92);
      do_tick(8'h23, 8'h15, 8'h30);
      check("R3 hours masked", alarm_flag, 1);
      clear_flag();
      reg_wr(2'd3, 8'h12);
      do_tick(8'h23, 8'h15, 8'h30);
      check("R3 hours unmasked", alarm_flag, 0);
   endtask

   task automatic t_field_bits();
      do_tick(8'hD2, 8'h95, 8'hB0);
      check("R4 extra time bits ignored", alarm_flag, 1);
      clear_flag();
      do_tick(8'h32, 8'h15, 8'h30);
      check("R4 hour tens bit counts", alarm_flag, 0);
   endtask

   task automatic t_all_masked();
      reg_wr(2'd1, 8'h80); reg_wr(2'd2, 8'h80); reg_wr(2'd3, 8'h80);
      do_tick(8'h07, 8'h42, 8'h18);
      check("R8 fires", alarm_flag, 1);
      clear_flag();
      do_tick(8'h21, 8'h03, 8'h59);
      check("R8 fires again", alarm_flag, 1);
      clear_flag();
   endtask

   task automatic t_collide();
      @(negedge clk);
      sec_tick = 1'b1; rd_en = 1'b1; addr = 2'd0;
      @(negedge clk);
      sec_tick = 1'b0; rd_en = 1'b0;
      check("R7 set wins", alarm_flag, 1);
      check("R7 read sees old flag", rd_data, 8'h00);
      clear_flag();
   endtask

   task automatic measure_high(input string req, input int exp);
      int n = 0;
      int guard = 0;
      while (int_out != 1'b1 && guard < 400) begin
         @(negedge clk); if (exp > 32) osc_en = ~osc_en; guard++;
      end
      while (int_out == 1'b1 && guard < 400) begin
         @(negedge clk); if (exp > 32) osc_en = ~osc_en; n++; guard++;
      end
      check(req, n, exp);
   endtask

   task automatic t_cal();
      logic [7:0] d;
      reg_wr(2'd0, 8'h04);
      reg_rd(2'd0, d);
      check("R9 cal readback", d, 8'h04);
      check("R10 wave starts low", int_out, 0);
      osc_en = 1'b1;
      measure_high("R10 half period every enable", 32);
      @(negedge clk);
      osc_en = 1'b0;
      measure_high("R10 half period alternate enable", 64);
      osc_en = 1'b0;
      do_tick(8'h00, 8'h00, 8'h00);
      reg_wr(2'd0, 8'h00);
      check("R9 int back to flag", int_out, alarm_flag);
      check("R9 flag still set", int_out, 1);
      clear_flag();
      check("R9 int low after clear", int_out, 0);
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_exact();
      t_read_clear();
      t_mask();
      t_field_bits();
      t_all_masked();
      t_collide();
      t_cal();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule